// File: doc/BRIEF.md
# Time-Slot Bus Arbiter

This block decides which of up to five bus masters may drive a shared on-chip bus. Time on the bus is cut into slots of equal length. A slot table that software can reprogram names the owner of each slot. The table is read in order and repeats, so a master's share of the bus depends only on how many table entries name it. Only the owner of the current slot can be granted, and only while it requests. If the owner is idle, the slot stays empty and no other master takes it. This keeps each master's bandwidth fixed whatever the other masters do.

A slot ends only when the bus reports that the transfer in flight has finished. A burst that runs past the nominal slot length therefore holds the grant until the bus is ready. Table writes go into a shadow copy, which is committed when the table wraps, so a pass through the table never mixes an old schedule with a new one. The arbiter outputs a one-hot grant vector and a 4-bit code for the granted master.

Top module: `tdma_arbiter`

## Requirements
- R1: A synchronous active-high reset loads table entry i with master index i mod 5, moves to entry 0 and starts the slot at its first cycle. While reset is held and on the first cycle after it, with all masters requesting, grant is 5'b00001 and owner is 0.
- R2: While bus_ready is high, every slot lasts exactly SLOT_CYCLES (64) clock cycles. The owner seen in the first cycle after reset stays for 64 cycles and changes on the 64th rising edge.
- R3: If bus_ready is low in the last cycle of a slot, that slot is extended. The next entry is taken on the first rising edge at which bus_ready is high.
- R4: At most one grant bit is high in any cycle.
- R5: If the current entry names a master whose request is low, grant is all zero and owner is 4'b1111, even if other masters request.
- R6: If the current entry names master m (m below 5) and req[m] is high, grant is exactly bit m. This follows req in the same cycle, with no register between req and grant.
- R7: A write (cfg_we high, cfg_addr selects the entry, cfg_data is the 3-bit master index) does not change the schedule in use. It takes effect when the pointer next wraps from the last entry to entry 0. A write on the wrap edge itself waits for the following wrap.
- R8: An entry holding 5, 6 or 7 names no master. Its slot grants nothing and shows owner 4'b1111.
- R9: Entries are used in address order 0 to 15 and the sequence then repeats from entry 0.
- R10: When a master is granted, owner carries its index zero-extended to 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 5 | Request lines, bit m for master m |
| bus_ready | input | 1 | High when the transfer in flight completes in this cycle |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | 4 | Table entry to write |
| cfg_data | input | 3 | Master index to store |
| grant | output | 5 | One-hot grant, bit m for master m |
| owner | output | 4 | Granted master index, 4'b1111 when none |

## Verification
The bench keeps its own arithmetic model of the counter, the pointer and both table copies. It compares grant and owner with that model in every cycle across several full passes of the table. Passes use the reset schedule, a reprogrammed schedule with empty-slot codes, and random requests and ready stalls. A design that lends an idle slot to another master fails the R5 checks. A design that does not stretch a slot while ready is low moves the owner one or more cycles early. A design that applies table writes at once instead of at the wrap shows the new owner in the middle of a pass. An off-by-one slot counter moves every boundary, and the R2 checks placed on both sides of each boundary catch it.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

    localparam int OWNER_CODE_W = 4;
    localparam logic [OWNER_CODE_W-1:0] NO_OWNER = '1;

    // Position of the slot counter within the current slot
    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_HOLD = 2'd1,
        PH_NEXT = 2'd2
    } slot_phase_e;

    // Result of the owner lookup
    typedef struct packed {
        logic                    hit;
        logic [OWNER_CODE_W-1:0] code;
    } owner_t;

    // Default schedule: entries dealt round-robin over the masters
    function automatic int unsigned rr_owner(input int unsigned slot,
                                             input int unsigned masters);
        return slot % masters;
    endfunction

endpackage

// File: rtl/slot_timer.sv
module slot_timer
    import tdma_pkg::*;
#(
    parameter int SLOT_CYCLES = 64,
    parameter int TABLE_DEPTH = 16,
    localparam int CNT_W = $clog2(SLOT_CYCLES),
    localparam int PTR_W = $clog2(TABLE_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_ready,
    output logic [PTR_W-1:0] slot_ptr,
    output logic             table_wrap
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_CYCLES - 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(TABLE_DEPTH - 1);

    logic [CNT_W-1:0] cnt;
    slot_phase_e      phase;

    always_comb begin
        if (cnt != CNT_LAST)  phase = PH_RUN;
        else if (!bus_ready)  phase = PH_HOLD;
        else                  phase = PH_NEXT;
    end

    assign table_wrap = (phase == PH_NEXT) && (slot_ptr == PTR_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            slot_ptr <= '0;
        end else begin
            case (phase)
                PH_RUN:  cnt <= cnt + CNT_W'(1);
                PH_NEXT: begin
                    cnt      <= '0;
                    slot_ptr <= (slot_ptr == PTR_LAST) ? '0 : slot_ptr + PTR_W'(1);
                end
                default: cnt <= cnt;
            endcase
        end
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != CNT_LAST) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R2
    ptr_still_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != CNT_LAST) |=> $stable(slot_ptr));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_LAST && !bus_ready) |=> ($stable(slot_ptr) && cnt == CNT_LAST));

    // R9
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        table_wrap |=> (slot_ptr == '0 && cnt == '0));

endmodule

// File: rtl/slot_table.sv
module slot_table
    import tdma_pkg::*;
#(
    parameter int TABLE_DEPTH = 16,
    parameter int NUM_MASTERS = 5,
    parameter int IDX_W       = 3,
    localparam int PTR_W = $clog2(TABLE_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [IDX_W-1:0] wr_data,
    input  logic             commit,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [IDX_W-1:0] rd_entry
);

    logic [TABLE_DEPTH-1:0][IDX_W-1:0] shadow;
    logic [TABLE_DEPTH-1:0][IDX_W-1:0] active;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TABLE_DEPTH; i++) begin
                shadow[i] <= IDX_W'(rr_owner(int'(i), NUM_MASTERS));
                active[i] <= IDX_W'(rr_owner(int'(i), NUM_MASTERS));
            end
        end else begin
            if (commit) active <= shadow;
            if (wr_en)  shadow[wr_addr] <= wr_data;
        end
    end

    assign rd_entry = active[rd_ptr];

    // R7
    active_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active));

    // R7
    commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> (active == $past(shadow)));

endmodule

// File: rtl/grant_gen.sv
module grant_gen
    import tdma_pkg::*;
#(
    parameter int NUM_MASTERS = 5,
    parameter int IDX_W       = 3
) (
    input  logic [NUM_MASTERS-1:0] req,
    input  logic [IDX_W-1:0]       entry,
    output logic [NUM_MASTERS-1:0] grant,
    output owner_t                 owner_sel
);

    always_comb begin
        grant          = '0;
        owner_sel.hit  = 1'b0;
        owner_sel.code = NO_OWNER;
        for (int m = 0; m < NUM_MASTERS; m++) begin
            if (entry == IDX_W'(m) && req[m]) begin
                grant[m]       = 1'b1;
                owner_sel.hit  = 1'b1;
                owner_sel.code = OWNER_CODE_W'(m);
            end
        end
    end

endmodule

// File: rtl/tdma_arbiter.sv
module tdma_arbiter
    import tdma_pkg::*;
#(
    parameter int NUM_MASTERS = 5,
    parameter int SLOT_CYCLES = 64,
    parameter int TABLE_DEPTH = 16,
    parameter int IDX_W       = 3,
    localparam int ADDR_W = $clog2(TABLE_DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_MASTERS-1:0]  req,
    input  logic                    bus_ready,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [IDX_W-1:0]        cfg_data,
    output logic [NUM_MASTERS-1:0]  grant,
    output logic [OWNER_CODE_W-1:0] owner
);

    logic [ADDR_W-1:0] slot_ptr;
    logic              table_wrap;
    logic [IDX_W-1:0]  slot_entry;
    owner_t            owner_sel;

    slot_timer #(
        .SLOT_CYCLES (SLOT_CYCLES),
        .TABLE_DEPTH (TABLE_DEPTH)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .bus_ready  (bus_ready),
        .slot_ptr   (slot_ptr),
        .table_wrap (table_wrap)
    );

    slot_table #(
        .TABLE_DEPTH (TABLE_DEPTH),
        .NUM_MASTERS (NUM_MASTERS),
        .IDX_W       (IDX_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_data),
        .commit   (table_wrap),
        .rd_ptr   (slot_ptr),
        .rd_entry (slot_entry)
    );

    grant_gen #(
        .NUM_MASTERS (NUM_MASTERS),
        .IDX_W       (IDX_W)
    ) u_grant (
        .req       (req),
        .entry     (slot_entry),
        .grant     (grant),
        .owner_sel (owner_sel)
    );

    assign owner = owner_sel.hit ? owner_sel.code : NO_OWNER;

    // R4
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R6
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

    // R5
    idle_code_chk: assert property (@(posedge clk) disable iff (rst)
        (grant == '0) == (owner == NO_OWNER));

    // R8
    empty_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(slot_entry) >= NUM_MASTERS) |-> (grant == '0));

endmodule

// File: tb/test_tdma_arbiter.sv
module test_tdma_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int NM    = 5;
    localparam int SC    = 64;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] req = '0;
    logic       bus_ready = 1'b1;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [2:0] cfg_data = '0;
    logic [4:0] grant;
    logic [3:0] owner;

    tdma_arbiter i_tdma_arbiter (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .bus_ready (bus_ready),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_data  (cfg_data),
        .grant     (grant),
        .owner     (owner)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    tests = 0;
    int    fails = 0;
    bit    finished = 0;
    string ctx = "R1 reset";

    int m_shadow [DEPTH];
    int m_active [DEPTH];
    int m_cnt = 0;
    int m_ptr = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    task automatic check(input string tag, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Reference model, applied with the inputs present at the edge
    task automatic model_edge;
        logic adv;
        if (rst) begin
            m_cnt = 0;
            m_ptr = 0;
            for (int i = 0; i < DEPTH; i++) begin
                m_shadow[i] = i % NM;
                m_active[i] = i % NM;
            end
        end else begin
            adv = (m_cnt == SC - 1) && bus_ready;
            if (adv && m_ptr == DEPTH - 1)
                for (int i = 0; i < DEPTH; i++) m_active[i] = m_shadow[i];
            if (cfg_we) m_shadow[cfg_addr] = int'(cfg_data);
            if (adv) begin
                m_cnt = 0;
                m_ptr = (m_ptr + 1) % DEPTH;
            end else if (m_cnt != SC - 1) begin
                m_cnt++;
            end
        end
    endtask

    task automatic compare;
        int own;
        int eg;
        int eo;
        string sel;
        own = m_active[m_ptr];
        if (own < NM && req[own]) begin
            eg = 1 << own;
            eo = own;
            sel = "R6 owner granted";
        end else begin
            eg = 0;
            eo = 15;
            sel = (own >= NM) ? "R8 empty entry" : "R5 idle owner";
        end
        check({ctx, " / ", sel, " grant"}, int'(grant), eg);
        check({ctx, " / R10 owner code"}, int'(owner), eo);
        check({ctx, " / R4 grant count"}, ($countones(grant) <= 1) ? 1 : 0, 1);
    endtask

    task automatic cycle(input logic [4:0] r, input logic rdy,
                         input logic we, input int a, input int d);
        @(posedge clk);
        model_edge();
        #1;
        req       = r;
        bus_ready = rdy;
        cfg_we    = we;
        cfg_addr  = a[3:0];
        cfg_data  = d[2:0];
        #1;
        compare();
    endtask

    function automatic logic [15:0] lfsr_next(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin
        // R1: reset state
        ctx = "R1 reset";
        repeat (3) cycle(5'h1F, 1'b1, 1'b0, 0, 0);
        check("R1 owner during reset", int'(owner), 0);
        check("R1 grant during reset", int'(grant), 1);
        rst = 1'b0;

        // R2 / R9: default schedule, boundaries on both sides
        ctx = "R2 R9 default schedule";
        for (int k = 1; k <= DEPTH * SC; k++) begin
            cycle(5'h1F, 1'b1, 1'b0, 0, 0);
            if (k == 1) check("R1 owner after reset", int'(owner), 0);
            if ((k % SC) == 0 || (k % SC) == SC - 1)
                check("R2 slot boundary owner", int'(owner), ((k / SC) % DEPTH) % NM);
        end
        check("R9 wrapped to entry 0", int'(owner), 0);

        // R5 / R6: random request patterns on the default table
        ctx = "R6 random requests";
        for (int k = 0; k < DEPTH * SC; k++) begin
            lfsr = lfsr_next(lfsr);
            cycle(lfsr[4:0], 1'b1, 1'b0, 0, 0);
        end

        // R7: reprogram mid-pass with a weighted table holding empty codes
        ctx = "R7 table write";
        for (int a = 0; a < DEPTH; a++) begin
            cycle(5'h1F, 1'b1, 1'b1, a, (a * 3 + 1) % 8);
            check("R7 write not applied yet", int'(owner), m_ptr % NM);
        end

        // R8: run the new schedule with all requests and with random ones
        ctx = "R8 reprogrammed table";
        for (int k = 0; k < 2 * DEPTH * SC; k++) begin
            lfsr = lfsr_next(lfsr);
            cycle((k < DEPTH * SC) ? 5'h1F : lfsr[4:0], 1'b1, 1'b0, 0, 0);
        end

        // R3: ready stalls at slot ends
        ctx = "R3 ready stalls";
        for (int k = 0; k < 2 * DEPTH * SC; k++) begin
            lfsr = lfsr_next(lfsr);
            cycle(lfsr[4:0], (lfsr[7:6] != 2'b00), 1'b0, 0, 0);
        end

        // R3: long hold at a boundary with all masters requesting
        ctx = "R3 long hold";
        while (m_cnt != SC - 2) cycle(5'h1F, 1'b1, 1'b0, 0, 0);
        for (int k = 0; k < 10; k++) cycle(5'h1F, 1'b0, 1'b0, 0, 0);
        cycle(5'h1F, 1'b1, 1'b0, 0, 0);
        cycle(5'h1F, 1'b1, 1'b0, 0, 0);

        // R1: reset in the middle of a run restores the default table
        ctx = "R1 re-reset";
        rst = 1'b1;
        cycle(5'h1F, 1'b1, 1'b0, 0, 0);
        rst = 1'b0;
        cycle(5'h1F, 1'b1, 1'b0, 0, 0);
        check("R1 owner after second reset", int'(owner), 0);
        for (int k = 0; k < DEPTH * SC; k++) cycle(5'h1F, 1'b1, 1'b0, 0, 0);

        report();
    end

endmodule